// File: doc/BRIEF.md
# Transition Pulse Encoder with Refresh

This block drives the send side of a pulse-coded isolation link. One logic input is brought into the clock domain through a two-flop synchroniser. Every change of level is turned into a short burst on a single pulse line. A burst of two pulses means the line is now high, and a burst of one pulse means it is now low. The receiver only sees pulses, so an input that never moves would leave it without information. To prevent this, the encoder repeats the present level on a timer whenever the input has been quiet for long enough. The receiver therefore stays correct at DC even if it missed an edge or started late.

Pulse width, the low gap inside a high pair, the quiet time before the first refresh and the repeat period are all parameters. A level change that arrives while a burst is still going out is remembered. It is served, using the newest level, as soon as the line is free again. After reset the first burst reports whatever level the input has at that point.

Top module: `pulse_refresh_encoder`

## Requirements
- R1: While `rst` is high, `pulse_out` is low from the clock edge after `rst` is first sampled high.
- R2: After `rst` is released, the first burst encodes the current `din` level. Its first pulse is visible 3 clock cycles after the cycle in which `rst` went low.
- R3: A high level is sent as two pulses, each PULSE_W cycles high, with exactly GAP_W low cycles between them. A low level is sent as a single pulse of PULSE_W cycles.
- R4: When the encoder is idle, a change on `din` produces a burst for the new level. The burst's first pulse is visible 3 cycles after the change: two synchroniser flops plus the registered output.
- R5: A `din` change that arrives during a burst is held. Once the running burst and its quiet tail end, a burst carrying the newest synchronised level starts at once, even if the level has returned to its old value.
- R6: Consecutive bursts are separated by at least GAP_W+2 low cycles.
- R7: A burst caused by an input change, or by the start after reset, restarts the refresh timer. If no further change occurs, a refresh burst carrying the present level starts exactly IDLE_CYC cycles after that burst started.
- R8: After a refresh burst, further refresh bursts follow every REFRESH_CYC cycles while the input stays still.
- R9: No burst appears on `pulse_out` other than those called for by R2, R4, R5, R7 and R8.
- R10: An input that changes every 10 cycles produces one burst per change, in order, each 3 cycles after its change. This holds with default pulse width and gap, since a burst plus its tail needs at most 2*PULSE_W+2*GAP_W+2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Logic input to be carried, asynchronous to `clk` |
| pulse_out | output | 1 | Registered pulse line towards the isolation barrier |

## Verification
Suppose the shaper state were wrong. A high would then come out as a single pulse, or the pair gap would differ from GAP_W, and this shows up within one burst length at the decoded pulse line. A stuck or mis-loaded refresh counter shifts the next refresh burst away from its exact expected cycle. This is visible IDLE_CYC or REFRESH_CYC cycles later. A lost held-edge flag makes the burst that should follow a busy period go missing, or leaves it carrying a stale level. The bench decodes every burst from the port and compares its level and start cycle against a queue of expected bursts, so any such error appears at the first affected burst.

// File: rtl/enc_pkg.sv
package enc_pkg;
  typedef enum logic [2:0] {
    SH_IDLE,
    SH_FIRST,
    SH_GAP,
    SH_SECOND,
    SH_TAIL
  } shaper_state_t;
endpackage

// File: rtl/level_sync.sv
module level_sync (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic chg,
  output logic valid
);
  logic s1, s2, prev, v1, v2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      prev <= 1'b0;
      v1   <= 1'b0;
      v2   <= 1'b0;
    end else begin
      s1   <= din;
      s2   <= s1;
      prev <= s2;
      v1   <= 1'b1;
      v2   <= v1;
    end
  end

  assign lvl   = s2;
  assign valid = v2;
  assign chg   = v2 & (s2 ^ prev);

  // R4: synchronised level lags the raw input by two sampled edges
  assert_sync_lag_R4: assert property (@(posedge clk) disable iff (rst)
    valid |-> (lvl == $past(din, 2)));
endmodule

// File: rtl/burst_shaper.sv
module burst_shaper
  import enc_pkg::*;
#(
  parameter int PULSE_W = 1,
  parameter int GAP_W   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic level,
  output logic busy,
  output logic pulse
);
  localparam int MAXV = (PULSE_W > GAP_W) ? PULSE_W : GAP_W;
  localparam int CW   = $clog2(MAXV + 2);

  shaper_state_t st;
  logic [CW-1:0] cnt;
  logic          hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SH_IDLE;
      cnt   <= '0;
      hi    <= 1'b0;
      pulse <= 1'b0;
    end else begin
      case (st)
        SH_IDLE: if (start) begin
          st    <= SH_FIRST;
          cnt   <= CW'(PULSE_W - 1);
          hi    <= level;
          pulse <= 1'b1;
        end
        SH_FIRST: if (cnt == '0) begin
          pulse <= 1'b0;
          if (hi) begin
            st  <= SH_GAP;
            cnt <= CW'(GAP_W - 1);
          end else begin
            st  <= SH_TAIL;
            cnt <= CW'(GAP_W);
          end
        end else cnt <= cnt - 1'b1;
        SH_GAP: if (cnt == '0) begin
          st    <= SH_SECOND;
          cnt   <= CW'(PULSE_W - 1);
          pulse <= 1'b1;
        end else cnt <= cnt - 1'b1;
        SH_SECOND: if (cnt == '0) begin
          st    <= SH_TAIL;
          cnt   <= CW'(GAP_W);
          pulse <= 1'b0;
        end else cnt <= cnt - 1'b1;
        SH_TAIL: if (cnt == '0) st <= SH_IDLE;
                 else cnt <= cnt - 1'b1;
        default: st <= SH_IDLE;
      endcase
    end
  end

  assign busy = (st != SH_IDLE);

  // R5: a new burst is only ever requested while the shaper is free
  assert_no_start_busy_R5: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  // R6: every pulse is followed by at least one low cycle
  assert_low_after_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse) |=> !pulse);
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int IDLE_CYC    = 100,
  parameter int REFRESH_CYC = 83
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_idle,
  output logic expire
);
  localparam int MAXC = (IDLE_CYC > REFRESH_CYC) ? IDLE_CYC : REFRESH_CYC;
  localparam int TW   = $clog2(MAXC + 1);

  logic [TW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      armed <= 1'b1;
      cnt   <= load_idle ? TW'(IDLE_CYC - 1) : TW'(REFRESH_CYC - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = armed & (cnt == '0);

  // R8: an expiry stays pending until a burst reloads the timer
  assert_expire_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (expire && !load) |=> expire);
endmodule

// File: rtl/pulse_refresh_encoder.sv
module pulse_refresh_encoder #(
  parameter int PULSE_W     = 1,
  parameter int GAP_W       = 2,
  parameter int IDLE_CYC    = 100,
  parameter int REFRESH_CYC = 83
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic pulse_out
);
  logic lvl, chg, valid, busy, expire;
  logic boot, pend, by_edge, go;

  level_sync u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .lvl  (lvl),
    .chg  (chg),
    .valid(valid)
  );

  assign by_edge = chg | pend | boot;
  assign go      = valid & ~busy & (by_edge | expire);

  always_ff @(posedge clk) begin
    if (rst) begin
      boot <= 1'b1;
      pend <= 1'b0;
    end else begin
      if (go) boot <= 1'b0;
      if (go)       pend <= 1'b0;
      else if (chg) pend <= 1'b1;
    end
  end

  refresh_timer #(
    .IDLE_CYC   (IDLE_CYC),
    .REFRESH_CYC(REFRESH_CYC)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (go),
    .load_idle(by_edge),
    .expire   (expire)
  );

  burst_shaper #(
    .PULSE_W(PULSE_W),
    .GAP_W  (GAP_W)
  ) u_shaper (
    .clk  (clk),
    .rst  (rst),
    .start(go),
    .level(lvl),
    .busy (busy),
    .pulse(pulse_out)
  );

  // R1: the line is quiet on the edge after reset is seen
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !pulse_out);
  // R2: the start-up request is served before any refresh can be
  assert_boot_first_R2: assert property (@(posedge clk) disable iff (rst)
    boot |-> !expire);
endmodule

// File: tb/pulse_refresh_encoder_tb.sv
module pulse_refresh_encoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 1;
  localparam int G  = 2;
  localparam int I  = 40;
  localparam int F  = 30;

  typedef struct {
    bit    lvl;
    int    t;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b1;
  logic pulse_out;
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  exp_t expq[$];

  pulse_refresh_encoder #(
    .PULSE_W(P), .GAP_W(G), .IDLE_CYC(I), .REFRESH_CYC(F)
  ) u_dut (
    .clk(clk), .rst(rst), .din(din), .pulse_out(pulse_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic push(bit l, int t, string req);
    exp_t e;
    e.lvl = l; e.t = t; e.req = req;
    expq.push_back(e);
  endtask

  task automatic to_cyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic got_burst(bit l, int t);
    exp_t e;
    if (expq.size() == 0) begin
      chk(1'b0, "R9", "unexpected burst start", t, -1);
    end else begin
      e = expq.pop_front();
      chk(l == e.lvl, e.req, "burst level", int'(l), int'(e.lvl));
      chk(t == e.t, e.req, "burst start cycle", t, e.t);
    end
  endtask

  // monitor: decode bursts from the pulse line
  initial begin
    int hi_run = 0;
    int lo_run = 1000;
    int npulse = 0;
    int bstart = 0;
    forever begin
      @(negedge clk);
      if (pulse_out) begin
        if (hi_run == 0) begin
          if (npulse == 0) begin
            chk(lo_run >= G + 2, "R6", "low cycles between bursts", lo_run, G + 2);
            bstart = cyc;
            npulse = 1;
          end else begin
            chk(lo_run == G, "R3", "gap inside high pair", lo_run, G);
            npulse = 2;
          end
        end
        hi_run++;
        lo_run = 0;
      end else begin
        if (hi_run > 0) chk(hi_run == P, "R3", "pulse width", hi_run, P);
        hi_run = 0;
        lo_run++;
        if (npulse == 2 && lo_run == 1) begin
          got_burst(1'b1, bstart);
          npulse = 0;
        end else if (npulse == 1 && lo_run == G + 1) begin
          got_burst(1'b0, bstart);
          npulse = 0;
        end
      end
    end
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  // driver
  initial begin
    // R1: line low during reset
    for (int k = 2; k <= 5; k++) begin
      to_cyc(k);
      chk(pulse_out == 1'b0, "R1", "pulse_out in reset", int'(pulse_out), 0);
    end
    to_cyc(6);
    rst = 1'b0;
    push(1'b1, 9,   "R2");
    push(1'b1, 49,  "R7");
    push(1'b1, 79,  "R8");
    push(1'b1, 109, "R8");
    // R4: falling change while idle
    to_cyc(120);
    din = 1'b0;
    push(1'b0, 123, "R4");
    push(1'b0, 163, "R7");
    // R4: rising change while idle
    to_cyc(173);
    din = 1'b1;
    push(1'b1, 176, "R4");
    // R5: change during the high burst is held
    to_cyc(177);
    din = 1'b0;
    push(1'b0, 184, "R5");
    // R5: double toggle during the low burst still yields a burst of the newest level
    to_cyc(184);
    din = 1'b1;
    to_cyc(185);
    din = 1'b0;
    push(1'b0, 189, "R5");
    // R10: input changing every 10 cycles
    for (int k = 0; k < 6; k++) begin
      to_cyc(200 + 10 * k);
      din = (k % 2 == 0);
      push(din, 203 + 10 * k, "R10");
    end
    push(1'b0, 293, "R7");
    push(1'b0, 323, "R8");
    to_cyc(345);
    // R9: nothing left unmatched and line idle
    chk(expq.size() == 0, "R9", "expected bursts left over", expq.size(), 0);
    chk(pulse_out == 1'b0, "R9", "pulse_out between refreshes", int'(pulse_out), 0);
    done = 1'b1;
    finish_run();
  end
endmodule